// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a real address by walking a multi-level radix tree of 64-bit entries held in memory. The caller supplies the root table base, the index width of the root table, the total address-space size in bits and the address to translate, then pulses `start`. The walker then issues one 64-bit read at a time over a request/response port and decodes each entry as it returns.

Each directory entry gives the base of the next table and the index width of that table. The index width is checked against a fixed set of allowed tree shapes before every read. The walk ends at the first leaf entry or at the first fault. On success the block reports the real address, the page size in bits, the leaf entry and the address it was read from. A fault is reported through a flag and a one-hot cause vector. Either outcome is signalled by a single-cycle `done` pulse, and the walker returns to idle in the same cycle.

Entry layout: bit 63 is valid and bit 62 is leaf. In a directory entry, bits 55:8 hold the next table base and bits 4:0 hold the next index width. In a leaf, bits 55:12 hold the page-number field.

Top module: `radix_walker`

## Requirements
- R1: The index at each level is (address >> (remaining size − index width)) masked to the index width. The entry is read from the realigned table base + index × 8, so every read address is a multiple of 8.
- R2: A table base, root or from a directory entry, that has any of its low (index width + 3) bits set has those bits cleared. The walk continues with no fault.
- R3: An entry whose valid bit (63) is clear ends the walk with `fault`=1 and `fault_cause`=2'b01 (no entry). No further read is issued.
- R4: A valid entry with bit 62 clear is a directory. The next read uses bits 55:8 as the table base and bits 4:0 as the index width, and the remaining size is reduced by the current index width.
- R5: Before each read the level is checked. Level 0 needs total size 52 and index width 13. Levels 1 and 2 need width 9. Level 3 accepts width 9 or 5. Any other combination, and any level from 4 up, ends the walk without that read, with `fault`=1 and `fault_cause`=2'b10 (bad configuration).
- R6: On a leaf, `real_addr` takes leaf bits 55:12 above the remaining size and the input address bits below it.
- R7: `page_size` equals the remaining size at the leaf: the total size minus the sum of the index widths of all levels read.
- R8: On success, `leaf_entry` holds the leaf as read, `leaf_addr` holds its address, and `fault` and `fault_cause` are zero.
- R9: At most one read is outstanding: `req_valid` stays low from the accepted request until its response. While `req_valid` waits for `req_ready`, `req_addr` is held stable.
- R10: `start` is taken only while `ready` is high. A start pulse during a walk does not change that walk's reads or result.
- R11: `done` is high for exactly one cycle per walk, and `ready` is high in that same cycle.
- R12: After reset the walker is idle: `ready`=1, `req_valid`=0, `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when ready) |
| ready | output | 1 | Walker idle |
| root_base | input | AW | Root table base address |
| root_nls | input | 5 | Root table index width |
| total_size | input | 7 | Address-space size in bits |
| vaddr | input | AW | Address to translate |
| req_valid | output | 1 | Memory read request |
| req_ready | input | 1 | Memory accepts request |
| req_addr | output | AW | Entry address to read |
| resp_valid | input | 1 | Read data valid |
| resp_data | input | 64 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | bit0 no entry, bit1 bad configuration |
| real_addr | output | AW | Translated address |
| page_size | output | 7 | Page size in bits |
| leaf_entry | output | 64 | Leaf entry as read |
| leaf_addr | output | AW | Address of leaf entry |

## Verification
The bench targets several corner cases, and each one exposes a specific mistake:
- Misaligned root and directory bases: a walker that faults on them, or uses the low bits as given, reads the wrong entries.
- Width-5 last level and leaves at levels 0, 1 and 2: an off-by-one in the remaining-size subtraction shows up as a wrong page size and a wrong split of `real_addr` between page bits and offset bits.
- Bad-configuration walks at level 0, level 1, level 3 and a non-leaf at level 3: a walker that checks after the read instead of before shows one extra read.
- A start pulse in mid-walk: a walker that accepts it would restart at the wrong address.

// File: rtl/rw_pkg.sv
package rw_pkg;
   localparam int ENTRY_W   = 64;
   localparam int NLS_W     = 5;
   localparam int SIZE_W    = 7;
   localparam int CAUSE_W   = 2;
   localparam int VALID_BIT = 63;
   localparam int LEAF_BIT  = 62;
   localparam int CAUSE_NO_ENTRY = 0;
   localparam int CAUSE_BAD_CFG  = 1;
   localparam logic [ENTRY_W-1:0] NEXT_BASE_FIELD = 64'h00FF_FFFF_FFFF_FF00;
   localparam logic [ENTRY_W-1:0] PAGE_NUM_FIELD  = 64'h00FF_FFFF_FFFF_F000;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CHECK,
      ST_REQ,
      ST_WAIT
   } walk_state_t;
endpackage

// File: rtl/rw_index_gen.sv
module rw_index_gen #(
   parameter int AW = 64
) (
   input  logic [AW-1:0]            tbl_base,
   input  logic [rw_pkg::NLS_W-1:0] nls,
   input  logic [rw_pkg::SIZE_W-1:0] remaining,
   input  logic [AW-1:0]            vaddr,
   output logic [AW-1:0]            entry_addr
);
   localparam int SW = rw_pkg::SIZE_W;

   logic [SW-1:0] shamt;
   logic [SW-1:0] align_sh;
   logic [AW-1:0] align_mask;
   logic [AW-1:0] idx_mask;
   logic [AW-1:0] index;

   always_comb begin
      shamt      = remaining - SW'(nls);
      align_sh   = SW'(nls) + SW'(3);
      align_mask = {AW{1'b1}} << align_sh;
      idx_mask   = ~({AW{1'b1}} << nls);
      index      = (vaddr >> shamt) & idx_mask;
      entry_addr = (tbl_base & align_mask) + (index << 3);
   end
endmodule

// File: rtl/rw_level_check.sv
module rw_level_check #(
   parameter int LVL_W      = 3,
   parameter int NUM_LEVELS = 4,
   parameter int ROOT_SIZE  = 52,
   parameter int ROOT_NLS   = 13,
   parameter int MID_NLS    = 9,
   parameter int LAST_NLS_A = 9,
   parameter int LAST_NLS_B = 5
) (
   input  logic [LVL_W-1:0]          level,
   input  logic [rw_pkg::NLS_W-1:0]  nls,
   input  logic [rw_pkg::SIZE_W-1:0] remaining,
   output logic                      cfg_ok
);
   localparam int NW = rw_pkg::NLS_W;
   localparam int SW = rw_pkg::SIZE_W;

   logic [NUM_LEVELS-1:0] lvl_ok;

   for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_rule
      if (g == 0) begin : g_root
         assign lvl_ok[g] = (remaining == SW'(ROOT_SIZE)) && (nls == NW'(ROOT_NLS));
      end else if (g == NUM_LEVELS - 1) begin : g_last
         assign lvl_ok[g] = (nls == NW'(LAST_NLS_A)) || (nls == NW'(LAST_NLS_B));
      end else begin : g_mid
         assign lvl_ok[g] = (nls == NW'(MID_NLS));
      end
   end

   always_comb begin
      cfg_ok = 1'b0;
      for (int i = 0; i < NUM_LEVELS; i++) begin
         if (level == LVL_W'(i)) cfg_ok = lvl_ok[i];
      end
   end
endmodule

// File: rtl/rw_addr_merge.sv
module rw_addr_merge #(
   parameter int AW = 64
) (
   input  logic [rw_pkg::ENTRY_W-1:0] entry,
   input  logic [rw_pkg::SIZE_W-1:0]  page_bits,
   input  logic [AW-1:0]              vaddr,
   output logic [AW-1:0]              real_addr
);
   logic [AW-1:0] page_mask;
   logic [AW-1:0] page_num;

   always_comb begin
      page_mask = ~({AW{1'b1}} << page_bits);
      page_num  = entry[AW-1:0] & rw_pkg::PAGE_NUM_FIELD[AW-1:0];
      real_addr = (page_num & ~page_mask) | (vaddr & page_mask);
   end
endmodule

// File: rtl/radix_walker.sv
module radix_walker #(
   parameter int AW         = 64,
   parameter int LVL_W      = 3,
   parameter int NUM_LEVELS = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   output logic                       ready,
   input  logic [AW-1:0]              root_base,
   input  logic [rw_pkg::NLS_W-1:0]   root_nls,
   input  logic [rw_pkg::SIZE_W-1:0]  total_size,
   input  logic [AW-1:0]              vaddr,
   output logic                       req_valid,
   input  logic                       req_ready,
   output logic [AW-1:0]              req_addr,
   input  logic                       resp_valid,
   input  logic [rw_pkg::ENTRY_W-1:0] resp_data,
   output logic                       done,
   output logic                       fault,
   output logic [rw_pkg::CAUSE_W-1:0] fault_cause,
   output logic [AW-1:0]              real_addr,
   output logic [rw_pkg::SIZE_W-1:0]  page_size,
   output logic [rw_pkg::ENTRY_W-1:0] leaf_entry,
   output logic [AW-1:0]              leaf_addr
);
   import rw_pkg::*;

   if (AW < 56 || AW > ENTRY_W) begin : g_bad_aw
      $error("radix_walker: AW must lie in 56..64");
   end
   if ((2 ** LVL_W) <= NUM_LEVELS) begin : g_bad_lvl
      $error("radix_walker: LVL_W too narrow for NUM_LEVELS");
   end

   walk_state_t        state;
   logic [AW-1:0]      va_q;
   logic [AW-1:0]      ent_addr_q;
   logic [NLS_W-1:0]   nls_q;
   logic [SIZE_W-1:0]  rem_q;
   logic [LVL_W-1:0]   lvl_q;

   logic [SIZE_W-1:0]  rem_next;
   logic [AW-1:0]      ig_base;
   logic [NLS_W-1:0]   ig_nls;
   logic [SIZE_W-1:0]  ig_rem;
   logic [AW-1:0]      ig_va;
   logic [AW-1:0]      ig_addr;
   logic               cfg_ok;
   logic [AW-1:0]      merged_addr;
   logic               is_idle;

   assign is_idle   = (state == ST_IDLE);
   assign ready     = is_idle;
   assign req_valid = (state == ST_REQ);
   assign req_addr  = ent_addr_q;
   assign rem_next  = rem_q - SIZE_W'(nls_q);

   always_comb begin
      if (is_idle) begin
         ig_base = root_base;
         ig_nls  = root_nls;
         ig_rem  = total_size;
         ig_va   = vaddr;
      end else begin
         ig_base = resp_data[AW-1:0] & NEXT_BASE_FIELD[AW-1:0];
         ig_nls  = resp_data[NLS_W-1:0];
         ig_rem  = rem_next;
         ig_va   = va_q;
      end
   end

   rw_index_gen #(.AW(AW)) u_index (
      .tbl_base  (ig_base),
      .nls       (ig_nls),
      .remaining (ig_rem),
      .vaddr     (ig_va),
      .entry_addr(ig_addr)
   );

   rw_level_check #(.LVL_W(LVL_W), .NUM_LEVELS(NUM_LEVELS)) u_check (
      .level    (lvl_q),
      .nls      (nls_q),
      .remaining(rem_q),
      .cfg_ok   (cfg_ok)
   );

   rw_addr_merge #(.AW(AW)) u_merge (
      .entry    (resp_data),
      .page_bits(rem_next),
      .vaddr    (va_q),
      .real_addr(merged_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         va_q        <= '0;
         ent_addr_q  <= '0;
         nls_q       <= '0;
         rem_q       <= '0;
         lvl_q       <= '0;
         done        <= 1'b0;
         fault       <= 1'b0;
         fault_cause <= '0;
         real_addr   <= '0;
         page_size   <= '0;
         leaf_entry  <= '0;
         leaf_addr   <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  va_q       <= vaddr;
                  nls_q      <= root_nls;
                  rem_q      <= total_size;
                  lvl_q      <= '0;
                  ent_addr_q <= ig_addr;
                  state      <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               if (cfg_ok) begin
                  state <= ST_REQ;
               end else begin
                  done        <= 1'b1;
                  fault       <= 1'b1;
                  fault_cause <= CAUSE_W'(1 << CAUSE_BAD_CFG);
                  state       <= ST_IDLE;
               end
            end
            ST_REQ: begin
               if (req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (resp_valid) begin
                  if (!resp_data[VALID_BIT]) begin
                     done        <= 1'b1;
                     fault       <= 1'b1;
                     fault_cause <= CAUSE_W'(1 << CAUSE_NO_ENTRY);
                     state       <= ST_IDLE;
                  end else if (resp_data[LEAF_BIT]) begin
                     done        <= 1'b1;
                     fault       <= 1'b0;
                     fault_cause <= '0;
                     real_addr   <= merged_addr;
                     page_size   <= rem_next;
                     leaf_entry  <= resp_data;
                     leaf_addr   <= ent_addr_q;
                     state       <= ST_IDLE;
                  end else begin
                     rem_q      <= rem_next;
                     nls_q      <= resp_data[NLS_W-1:0];
                     ent_addr_q <= ig_addr;
                     lvl_q      <= lvl_q + LVL_W'(1);
                     state      <= ST_CHECK;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
   parameter int AW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ready,
   input logic          req_valid,
   input logic          req_ready,
   input logic [AW-1:0] req_addr,
   input logic          resp_valid,
   input logic          done,
   input logic          fault,
   input logic [1:0]    fault_cause
);
   logic pend;

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= 1'b0;
      else if (req_valid && req_ready) pend <= 1'b1;
      else if (resp_valid) pend <= 1'b0;
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R9
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> !req_valid); // R9
   AST_REQ_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_addr[2:0] == 3'b000); // R1
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready); // R11
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !req_valid); // R10
   AST_FAULT_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      done && fault |-> $countones(fault_cause) == 1); // R3
   AST_SUCCESS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      done && !fault |-> fault_cause == 2'b00); // R8
endmodule

bind radix_walker radix_walker_chk #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ready      (ready),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .resp_valid (resp_valid),
   .done       (done),
   .fault      (fault),
   .fault_cause(fault_cause)
);

// File: tb/radix_walker_test.sv
module radix_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        ready;
   logic [63:0] root_base = '0;
   logic [4:0]  root_nls = '0;
   logic [6:0]  total_size = '0;
   logic [63:0] vaddr = '0;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [63:0] req_addr;
   logic        resp_valid = 1'b0;
   logic [63:0] resp_data = '0;
   logic        done;
   logic        fault;
   logic [1:0]  fault_cause;
   logic [63:0] real_addr;
   logic [6:0]  page_size;
   logic [63:0] leaf_entry;
   logic [63:0] leaf_addr;

   radix_walker uut (
      .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
      .root_base(root_base), .root_nls(root_nls), .total_size(total_size),
      .vaddr(vaddr), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
      .done(done), .fault(fault), .fault_cause(fault_cause),
      .real_addr(real_addr), .page_size(page_size),
      .leaf_entry(leaf_entry), .leaf_addr(leaf_addr)
   );

   always #5 clk = ~clk;

   localparam logic [63:0] NB_MASK  = 64'h00FF_FFFF_FFFF_FF00;
   localparam logic [63:0] PN_MASK  = 64'h00FF_FFFF_FFFF_F000;

   int checks = 0;
   int fails  = 0;
   logic [63:0] mem [logic [63:0]];

   // request log filled by the responder
   logic [63:0] req_log [16];
   int          req_cnt = 0;
   bit          r9_bad = 0;

   // reference results
   bit          e_fault;
   logic [1:0]  e_cause;
   logic [63:0] e_ra, e_leaf, e_laddr;
   int          e_ps, e_nreads;
   logic [63:0] e_addrs [8];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] rd(input logic [63:0] a);
      return mem.exists(a) ? mem[a] : 64'd0;
   endfunction

   function automatic logic [63:0] ent_addr(input logic [63:0] base, input int nls, input int ps, input logic [63:0] va);
      logic [63:0] am, idx;
      am  = (64'd1 << (nls + 3)) - 64'd1;
      idx = (va >> (ps - nls)) & ((64'd1 << nls) - 64'd1);
      return (base & ~am) + idx * 8;
   endfunction

   function automatic bit cfg_ok(input int lvl, input int ps, input int nls);
      return (lvl == 0 && ps == 52 && nls == 13) || ((lvl == 1 || lvl == 2) && nls == 9)
          || (lvl == 3 && (nls == 9 || nls == 5));
   endfunction

   task automatic ref_walk(input logic [63:0] base, input int nls0, input int tsz, input logic [63:0] va);
      int ps, nls;
      logic [63:0] a, e, pm;
      ps = tsz; nls = nls0; e_nreads = 0; e_fault = 0; e_cause = 0;
      a = ent_addr(base, nls, ps, va);
      for (int lvl = 0; lvl < 8; lvl++) begin
         if (!cfg_ok(lvl, ps, nls)) begin e_fault = 1; e_cause = 2'b10; return; end
         e_addrs[e_nreads] = a; e_nreads++;
         e = rd(a);
         if (!e[63]) begin e_fault = 1; e_cause = 2'b01; return; end
         ps -= nls;
         if (e[62]) begin
            pm = ~(~64'd0 << ps);
            e_ra = (e & PN_MASK & ~pm) | (va & pm);
            e_ps = ps; e_leaf = e; e_laddr = a;
            return;
         end
         nls = int'(e[4:0]);
         a = ent_addr(e & NB_MASK, nls, ps, va);
      end
   endtask

   function automatic logic [63:0] mk_dir(input logic [63:0] base, input int nls);
      logic [63:0] e;
      e = base & NB_MASK;
      e[63] = 1'b1;
      e[4:0] = 5'(nls);
      return e;
   endfunction

   // build a path for va; nls_l[k] is the index width of level k
   task automatic build(input logic [63:0] rb, input logic [63:0] va, input int n0, input int n1,
                        input int n2, input int n3, input int n4, input int leaf_lvl, input int bad_lvl,
                        input bit misalign);
      int nl[5];
      int ps;
      logic [63:0] cur, a, nb, e;
      nl[0] = n0; nl[1] = n1; nl[2] = n2; nl[3] = n3; nl[4] = n4;
      mem.delete();
      cur = rb; ps = 52;
      for (int lvl = 0; lvl < 5; lvl++) begin
         a = ent_addr(cur, nl[lvl], ps, va);
         ps -= nl[lvl];
         if (lvl == bad_lvl) begin
            mem[a] = {1'b0, 31'($urandom), $urandom};
            return;
         end
         if (lvl == leaf_lvl) begin
            e = ({$urandom, $urandom} & PN_MASK) | 64'(($urandom & 32'h7F) << 5);
            e[63] = 1'b1; e[62] = 1'b1;
            mem[a] = e;
            return;
         end
         if (lvl == 4) return;
         nb = {$urandom, $urandom} & 64'h00FF_FFFF_FFFF_F000;
         if (misalign) nb = nb | 64'h0000_0000_0000_0B00;
         mem[a] = mk_dir(nb, nl[lvl + 1]);
         cur = nb;
      end
   endtask

   // memory responder: one-cycle latency, random ready
   initial begin
      bit          pend = 0;
      logic [63:0] paddr = '0;
      forever begin
         @(negedge clk);
         resp_valid = 1'b0;
         if (!rst_n) begin
            req_ready = 1'b0;
            pend = 0;
         end else begin
            if (pend && req_valid) r9_bad = 1;
            if (pend) begin
               resp_valid = 1'b1;
               resp_data  = rd(paddr);
               pend = 0;
            end
            req_ready = ($urandom % 4) != 0;
            if (req_valid && req_ready) begin
               pend = 1;
               paddr = req_addr;
               if (req_cnt < 16) req_log[req_cnt] = req_addr;
               req_cnt++;
            end
         end
      end
   end

   task automatic run_walk(input string name, input logic [63:0] rb, input int n0, input int tsz,
                           input logic [63:0] va, input bit poke);
      int n;
      ref_walk(rb, n0, tsz, va);
      @(negedge clk);
      req_cnt = 0;
      root_base = rb; root_nls = 5'(n0); total_size = 7'(tsz); vaddr = va;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         chk(ready == 1'b0, {name, " R10 busy"}, 64'(ready), 64'd0);
         root_base = ~rb; root_nls = 5'd9; total_size = 7'd52; vaddr = ~va;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      n = 0;
      while (!done && n < 500) begin
         @(negedge clk);
         n++;
      end
      if (!done) begin
         chk(1'b0, {name, " R11 done timeout"}, 64'd0, 64'd1);
         return;
      end
      chk(ready == 1'b1, {name, " R11 ready with done"}, 64'(ready), 64'd1);
      chk(fault == e_fault, {name, e_cause == 2'b10 ? " R5 fault" : " R3 fault"}, 64'(fault), 64'(e_fault));
      chk(fault_cause == (e_fault ? e_cause : 2'b00), {name, e_cause == 2'b10 ? " R5 cause" : " R3 cause"},
          64'(fault_cause), 64'(e_fault ? e_cause : 2'b00));
      chk(req_cnt == e_nreads, {name, " R4 read count"}, 64'(req_cnt), 64'(e_nreads));
      for (int k = 0; k < e_nreads && k < req_cnt; k++)
         chk(req_log[k] == e_addrs[k], {name, " R1 read address"}, req_log[k], e_addrs[k]);
      if (!e_fault) begin
         chk(real_addr == e_ra, {name, " R6 real address"}, real_addr, e_ra);
         chk(page_size == 7'(e_ps), {name, " R7 page size"}, 64'(page_size), 64'(e_ps));
         chk(leaf_entry == e_leaf, {name, " R8 leaf entry"}, leaf_entry, e_leaf);
         chk(leaf_addr == e_laddr, {name, " R8 leaf address"}, leaf_addr, e_laddr);
      end
      @(negedge clk);
      chk(done == 1'b0, {name, " R11 single pulse"}, 64'(done), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [63:0] rb, va;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready == 1'b1, "R12 ready after reset", 64'(ready), 64'd1);
      chk(req_valid == 1'b0, "R12 no request after reset", 64'(req_valid), 64'd0);
      chk(done == 1'b0, "R12 no done after reset", 64'(done), 64'd0);

      rb = 64'h0000_1234_5600_0000;
      va = 64'h000F_EDCB_A987_6543;
      build(rb, va, 13, 9, 9, 9, 9, 3, -1, 0); run_walk("4K R7", rb, 13, 52, va, 0);
      build(rb, va, 13, 9, 9, 9, 9, 2, -1, 0); run_walk("2M R7", rb, 13, 52, va, 0);
      build(rb, va, 13, 9, 9, 9, 9, 1, -1, 0); run_walk("1G R7", rb, 13, 52, va, 0);
      build(rb, va, 13, 9, 9, 9, 9, 0, -1, 0); run_walk("root leaf R6", rb, 13, 52, va, 0);
      build(rb, va, 13, 9, 9, 5, 9, 3, -1, 0); run_walk("64K R5", rb, 13, 52, va, 0);
      build(rb, va, 13, 9, 9, 9, 9, 3, 2, 0);  run_walk("invalid L2 R3", rb, 13, 52, va, 0);
      build(rb, va, 13, 9, 9, 9, 9, 3, 0, 0);  run_walk("invalid root R3", rb, 13, 52, va, 0);
      build(rb, va, 13, 9, 9, 9, 9, 3, -1, 0); run_walk("size 48 R5", rb, 13, 48, va, 0);
      run_walk("root nls 12 R5", rb, 12, 52, va, 0);
      build(rb, va, 13, 10, 9, 9, 9, 3, -1, 0); run_walk("L1 nls 10 R5", rb, 13, 52, va, 0);
      build(rb, va, 13, 9, 9, 7, 9, 3, -1, 0);  run_walk("L3 nls 7 R5", rb, 13, 52, va, 0);
      build(rb, va, 13, 9, 9, 9, 9, 9, -1, 0);  run_walk("too deep R5", rb, 13, 52, va, 0);
      build(rb & ~64'hFFFF, va, 13, 9, 9, 9, 9, 3, -1, 1);
      run_walk("misaligned R2", rb | 64'h0000_0000_0000_A5A8, 13, 52, va, 0);
      build(rb, va, 13, 9, 9, 9, 9, 3, -1, 0);  run_walk("busy start R10", rb, 13, 52, va, 1);

      for (int t = 0; t < 400; t++) begin
         int leaf, bad, n1, n2, n3;
         bit mis;
         rb   = {$urandom, $urandom} & 64'h00FF_FFFF_FFFF_0000;
         mis  = ($urandom % 4) == 0;
         if (mis) rb = rb | 64'(($urandom & 32'hFFF8));
         va   = {$urandom, $urandom} & 64'h000F_FFFF_FFFF_FFFF;
         leaf = int'($urandom % 4);
         bad  = (($urandom % 8) == 0) ? int'($urandom % 4) : -1;
         n1 = 9; n2 = 9; n3 = (($urandom % 2) == 0) ? 9 : 5;
         if (($urandom % 12) == 0) n2 = int'($urandom % 20);
         if (($urandom % 12) == 0) n3 = int'($urandom % 20);
         build(rb & ~64'hFFFF, va, 13, n1, n2, n3, 9, leaf, bad, mis);
         run_walk("random R1", rb, 13, 52, va, ($urandom % 10) == 0);
      end

      chk(r9_bad == 1'b0, "R9 one outstanding read", 64'(r9_bad), 64'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule